// File: doc/BRIEF.md
# Dual Nibble-RAM Stack Engine

This block is the stack address unit of a small zero-address CPU with a 4-bit datapath. The CPU keeps two stacks in one shared 256 x 4 RAM, and this block maintains the pointers for both of them.

The expression stack keeps its top item in a register of its own. Its pointer addresses the item directly underneath that top item. The return stack holds 12-bit entries. Each entry takes three nibbles, and the return pointer advances by a whole four-nibble slot, so the fourth nibble of every slot is left alone.

The surrounding core issues one command per cycle. The block turns each command into a RAM address, write data and a write enable. It refills the top register when the expression stack is popped. It also runs the three-cycle nibble sequence that moves a return entry into or out of the RAM. The RAM is outside the block and is read asynchronously: `ramRdata` follows `ramAddr` within the same cycle.

Top module: `stack_engine`

## Requirements
- R1: While reset is asserted and after it is released, `busy` and `retValid` stay low and no RAM write takes place until a command is accepted. The pointers and the top register are not initialised and must be loaded before use.
- R2: Expression push (`cmd`=1) is accepted when `cmdValid` is high and `busy` is low. In the accept cycle the old top value is written to address `sp`+1. On the next edge `sp` becomes `sp`+1 and `tos` takes `pushNib`.
- R3: Expression pop (`cmd`=2) reads the RAM at `sp` in the accept cycle. On the next edge `tos` takes that nibble and `sp` becomes `sp`-1.
- R4: Pointer loads (`cmd`=5 for `sp`, `cmd`=6 for `rp`) take `ldVal` on the next edge. They make no RAM write and leave `tos` unchanged.
- R5: Return push (`cmd`=3) sets `rp` to `rp`+4 on the accept edge. During the next three cycles, with `busy` high, it writes `retIn[3:0]`, `retIn[7:4]` and `retIn[11:8]` to the new `rp`, `rp`+1 and `rp`+2.
- R6: Return-stack transfers never write the fourth nibble of a slot (offset 3 from `rp`).
- R7: Return pop (`cmd`=4) reads `rp`, `rp`+1 and `rp`+2 during the three cycles after the accept cycle, with `busy` high. On the last of these edges `rp` drops by 4, `retOut` holds the rebuilt entry (first nibble read is least significant) and `retValid` rises for exactly one cycle.
- R8: A command offered while `busy` is high is ignored: pointers, `tos` and the transfer in progress are unaffected.
- R9: All pointer arithmetic wraps modulo 256 and raises no flag (`sp` FFh+1 gives 00h, `rp` FCh+4 gives 00h, 00h-4 gives FCh).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset of the control state |
| cmdValid | input | 1 | Command strobe |
| cmd | input | 3 | Command code (1 epush, 2 epop, 3 rpush, 4 rpop, 5 load sp, 6 load rp) |
| pushNib | input | 4 | Nibble pushed onto the expression stack |
| ldVal | input | 8 | Value for a pointer load |
| retIn | input | 12 | Entry pushed onto the return stack |
| ramRdata | input | 4 | Read data of the shared RAM (asynchronous read) |
| ramAddr | output | 8 | RAM address |
| ramWe | output | 1 | RAM write enable |
| ramWdata | output | 4 | RAM write data |
| tos | output | 4 | Top-of-stack register |
| sp | output | 8 | Expression-stack pointer (item below the top) |
| rp | output | 8 | Return-stack pointer (slot base of the top entry) |
| retOut | output | 12 | Entry returned by the last return pop |
| retValid | output | 1 | One-cycle pulse when `retOut` is updated |
| busy | output | 1 | High while a return-stack transfer is running |

## Verification
The bench builds the block with its default parameters: 8-bit pointers, 4-bit nibbles, and three-nibble entries in four-nibble slots. With these values both wrap points are only a few commands away from a loaded pointer. A pointer loaded with FDh crosses FFh to 00h and back on expression traffic, and a return pointer loaded with FCh wraps on its very first push and on the matching pop. The untouched fourth nibble of each slot is preloaded with a marker in the bench RAM and read back after the transfers.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_EPUSH = 3'd1,
    CMD_EPOP  = 3'd2,
    CMD_RPUSH = 3'd3,
    CMD_RPOP  = 3'd4,
    CMD_LDSP  = 3'd5,
    CMD_LDRP  = 3'd6
  } stkCmd_e;

  typedef enum logic [1:0] {
    ADR_SPNEXT = 2'd0,
    ADR_SP     = 2'd1,
    ADR_RPSLOT = 2'd2
  } addrSel_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic     spInc;
    logic     spDec;
    logic     spLoad;
    logic     rpInc;
    logic     rpDec;
    logic     rpLoad;
    logic     tosFromIn;
    logic     tosFromRam;
    logic     retLatch;
    logic     retCapture;
    logic     retFinish;
    logic     ramWe;
    addrSel_e addrSel;
  } stkStrobe_t;

endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int RET_NIBS = 3,
  parameter int IDX_W    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [2:0]       cmd,
  output stkStrobe_t       strobe,
  output logic [IDX_W-1:0] nibIdx,
  output logic             busy
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RET_NIBS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_WRITE, ST_READ} state_e;

  state_e  state;
  stkCmd_e cmdIn;
  logic    accept;

  assign cmdIn  = stkCmd_e'(cmd);
  assign busy   = (state != ST_IDLE);
  assign accept = cmdValid && (state == ST_IDLE);

  always_comb begin
    strobe         = stkStrobe_t'('0);
    strobe.addrSel = ADR_SP;
    case (state)
      ST_IDLE: begin
        if (cmdValid) begin
          case (cmdIn)
            CMD_EPUSH: begin
              strobe.spInc     = 1'b1;
              strobe.tosFromIn = 1'b1;
              strobe.ramWe     = 1'b1;
              strobe.addrSel   = ADR_SPNEXT;
            end
            CMD_EPOP: begin
              strobe.spDec      = 1'b1;
              strobe.tosFromRam = 1'b1;
              strobe.addrSel    = ADR_SP;
            end
            CMD_RPUSH: begin
              strobe.rpInc    = 1'b1;
              strobe.retLatch = 1'b1;
            end
            CMD_LDSP: strobe.spLoad = 1'b1;
            CMD_LDRP: strobe.rpLoad = 1'b1;
            default: ;
          endcase
        end
      end
      ST_WRITE: begin
        strobe.ramWe   = 1'b1;
        strobe.addrSel = ADR_RPSLOT;
      end
      ST_READ: begin
        strobe.addrSel    = ADR_RPSLOT;
        strobe.retCapture = 1'b1;
        if (nibIdx == LAST_IDX) begin
          strobe.retFinish = 1'b1;
          strobe.rpDec     = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      nibIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          nibIdx <= '0;
          if (accept && cmdIn == CMD_RPUSH) state <= ST_WRITE;
          else if (accept && cmdIn == CMD_RPOP) state <= ST_READ;
        end
        default: begin
          if (nibIdx == LAST_IDX) begin
            state  <= ST_IDLE;
            nibIdx <= '0;
          end else begin
            nibIdx <= nibIdx + 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/stk_dpath.sv
module stk_dpath
  import stk_pkg::*;
#(
  parameter int NIB_W     = 4,
  parameter int ADDR_W    = 8,
  parameter int RET_NIBS  = 3,
  parameter int SLOT_NIBS = 4,
  parameter int IDX_W     = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  stkStrobe_t                strobe,
  input  logic [IDX_W-1:0]          nibIdx,
  input  logic [NIB_W-1:0]          pushNib,
  input  logic [ADDR_W-1:0]         ldVal,
  input  logic [RET_NIBS*NIB_W-1:0] retIn,
  input  logic [NIB_W-1:0]          ramRdata,
  output logic [ADDR_W-1:0]         ramAddr,
  output logic [NIB_W-1:0]          ramWdata,
  output logic [NIB_W-1:0]          tos,
  output logic [ADDR_W-1:0]         sp,
  output logic [ADDR_W-1:0]         rp,
  output logic [RET_NIBS*NIB_W-1:0] retOut,
  output logic                      retValid
);

  localparam logic [ADDR_W-1:0] SLOT_STEP = ADDR_W'(SLOT_NIBS);
  localparam logic [ADDR_W-1:0] ONE       = ADDR_W'(1);

  logic [RET_NIBS-1:0][NIB_W-1:0] retBuf;
  logic [RET_NIBS-1:0][NIB_W-1:0] popWord;

  // last nibble comes straight from the RAM on the finishing cycle
  for (genvar g = 0; g < RET_NIBS; g++) begin : g_pop
    if (g == RET_NIBS - 1) begin : g_last
      assign popWord[g] = ramRdata;
    end else begin : g_held
      assign popWord[g] = retBuf[g];
    end
  end

  always_comb begin
    case (strobe.addrSel)
      ADR_SPNEXT: ramAddr = sp + ONE;
      ADR_RPSLOT: ramAddr = rp + ADDR_W'(nibIdx);
      default:    ramAddr = sp;
    endcase
    ramWdata = (strobe.addrSel == ADR_RPSLOT) ? retBuf[nibIdx] : tos;
  end

  // pointers and data are left uninitialised by reset
  always_ff @(posedge clk) begin
    if (strobe.spLoad)      sp <= ldVal;
    else if (strobe.spInc)  sp <= sp + ONE;
    else if (strobe.spDec)  sp <= sp - ONE;

    if (strobe.rpLoad)      rp <= ldVal;
    else if (strobe.rpInc)  rp <= rp + SLOT_STEP;
    else if (strobe.rpDec)  rp <= rp - SLOT_STEP;

    if (strobe.tosFromIn)       tos <= pushNib;
    else if (strobe.tosFromRam) tos <= ramRdata;

    if (strobe.retLatch) retBuf <= retIn;
    else if (strobe.retCapture) retBuf[nibIdx] <= ramRdata;

    if (strobe.retFinish) retOut <= popWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) retValid <= 1'b0;
    else       retValid <= strobe.retFinish;
  end

endmodule

// File: rtl/stack_engine.sv
module stack_engine
  import stk_pkg::*;
#(
  parameter int NIB_W     = 4,
  parameter int ADDR_W    = 8,
  parameter int RET_NIBS  = 3,
  parameter int SLOT_NIBS = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cmdValid,
  input  logic [2:0]                cmd,
  input  logic [NIB_W-1:0]          pushNib,
  input  logic [ADDR_W-1:0]         ldVal,
  input  logic [RET_NIBS*NIB_W-1:0] retIn,
  input  logic [NIB_W-1:0]          ramRdata,
  output logic [ADDR_W-1:0]         ramAddr,
  output logic                      ramWe,
  output logic [NIB_W-1:0]          ramWdata,
  output logic [NIB_W-1:0]          tos,
  output logic [ADDR_W-1:0]         sp,
  output logic [ADDR_W-1:0]         rp,
  output logic [RET_NIBS*NIB_W-1:0] retOut,
  output logic                      retValid,
  output logic                      busy
);

  localparam int IDX_W = (RET_NIBS > 1) ? $clog2(RET_NIBS) : 1;

  stkStrobe_t       strobe;
  logic [IDX_W-1:0] nibIdx;

  assign ramWe = strobe.ramWe;

  stk_ctrl #(.RET_NIBS(RET_NIBS), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmd(cmd),
    .strobe(strobe), .nibIdx(nibIdx), .busy(busy)
  );

  stk_dpath #(
    .NIB_W(NIB_W), .ADDR_W(ADDR_W), .RET_NIBS(RET_NIBS),
    .SLOT_NIBS(SLOT_NIBS), .IDX_W(IDX_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .nibIdx(nibIdx),
    .pushNib(pushNib), .ldVal(ldVal), .retIn(retIn), .ramRdata(ramRdata),
    .ramAddr(ramAddr), .ramWdata(ramWdata), .tos(tos), .sp(sp), .rp(rp),
    .retOut(retOut), .retValid(retValid)
  );

endmodule

// File: rtl/stk_checker.sv
module stk_checker #(
  parameter int NIB_W     = 4,
  parameter int ADDR_W    = 8,
  parameter int RET_NIBS  = 3,
  parameter int SLOT_NIBS = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic [2:0]        cmd,
  input logic              busy,
  input logic [ADDR_W-1:0] sp,
  input logic [ADDR_W-1:0] rp,
  input logic [NIB_W-1:0]  tos,
  input logic [ADDR_W-1:0] ramAddr,
  input logic              ramWe,
  input logic [NIB_W-1:0]  ramRdata,
  input logic              retValid
);

  localparam logic [ADDR_W-1:0] ONE  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(SLOT_NIBS);

  logic              takeIt;
  logic [ADDR_W-1:0] slotOff;

  assign takeIt  = cmdValid && !busy;
  assign slotOff = ramAddr - rp;

  AST_RESET_QUIET: assert property (@(posedge clk) !rstN |-> (!busy && !retValid)); // R1

  AST_EPUSH_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (takeIt && cmd == 3'd1) |=> (sp == $past(sp) + ONE)); // R2

  AST_EPOP_REFILL: assert property (@(posedge clk) disable iff (!rstN)
    (takeIt && cmd == 3'd2) |=> (tos == $past(ramRdata) && sp == $past(sp) - ONE)); // R3

  AST_RPUSH_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (takeIt && cmd == 3'd3) |=> (busy && rp == $past(rp) + STEP)); // R5

  AST_SLOT_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (busy && ramWe) |-> (slotOff < ADDR_W'(RET_NIBS))); // R6

  AST_RET_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    retValid |=> !retValid); // R7

  AST_BUSY_HOLD_SP: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(sp)); // R8

endmodule

bind stack_engine stk_checker #(
  .NIB_W(NIB_W), .ADDR_W(ADDR_W), .RET_NIBS(RET_NIBS), .SLOT_NIBS(SLOT_NIBS)
) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmd(cmd), .busy(busy),
  .sp(sp), .rp(rp), .tos(tos), .ramAddr(ramAddr), .ramWe(ramWe),
  .ramRdata(ramRdata), .retValid(retValid)
);

// File: tb/test_stack_engine.sv
module test_stack_engine;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmd = 3'd0;
  logic [3:0]  pushNib = 4'h0;
  logic [7:0]  ldVal = 8'h00;
  logic [11:0] retIn = 12'h000;
  logic [3:0]  ramRdata;
  logic [7:0]  ramAddr;
  logic        ramWe;
  logic [3:0]  ramWdata;
  logic [3:0]  tos;
  logic [7:0]  sp;
  logic [7:0]  rp;
  logic [11:0] retOut;
  logic        retValid;
  logic        busy;

  logic [3:0] mem [256];
  int nChecks = 0;
  int nFail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign ramRdata = mem[ramAddr];
  always @(posedge clk) if (ramWe) mem[ramAddr] <= ramWdata;

  stack_engine i_stack_engine (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmd(cmd), .pushNib(pushNib),
    .ldVal(ldVal), .retIn(retIn), .ramRdata(ramRdata), .ramAddr(ramAddr),
    .ramWe(ramWe), .ramWdata(ramWdata), .tos(tos), .sp(sp), .rp(rp),
    .retOut(retOut), .retValid(retValid), .busy(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one command per row: {cmd, data, checkTos, expTos, expSp}
  localparam logic [23:0] VEC [12] = '{
    {3'd5, 8'hFD, 1'b0, 4'h0, 8'hFD},  // R4 load sp
    {3'd1, 8'h03, 1'b1, 4'h3, 8'hFE},  // R2
    {3'd1, 8'h07, 1'b1, 4'h7, 8'hFF},  // R2
    {3'd1, 8'h0A, 1'b1, 4'hA, 8'h00},  // R9 wrap up
    {3'd1, 8'h0C, 1'b1, 4'hC, 8'h01},  // R2
    {3'd2, 8'h00, 1'b1, 4'hA, 8'h00},  // R3
    {3'd2, 8'h00, 1'b1, 4'h7, 8'hFF},  // R3 wrap down
    {3'd1, 8'h01, 1'b1, 4'h1, 8'h00},  // R2
    {3'd2, 8'h00, 1'b1, 4'h7, 8'hFF},  // R3
    {3'd2, 8'h00, 1'b1, 4'h3, 8'hFE},  // R3
    {3'd5, 8'h00, 1'b1, 4'h3, 8'h00},  // R4 tos untouched
    {3'd2, 8'h00, 1'b1, 4'h7, 8'hFF}   // R9 pop from 00
  };

  task automatic issue(input logic [2:0] c, input logic [7:0] d, input logic [11:0] r);
    @(negedge clk);
    cmdValid = 1'b1; cmd = c; pushNib = d[3:0]; ldVal = d; retIn = r;
    @(negedge clk);
    cmdValid = 1'b0; cmd = 3'd0;
  endtask

  task automatic retPush(input logic [11:0] val, input logic [7:0] base);
    @(negedge clk);
    cmdValid = 1'b1; cmd = 3'd3; retIn = val;
    #1 chk("R5 no write in accept cycle", {31'd0, ramWe}, 32'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      // offer commands that must be ignored while busy
      cmdValid = (k < 2); cmd = (k == 0) ? 3'd5 : 3'd1; ldVal = 8'h55; pushNib = 4'hF;
      chk("R5 rp after push", {24'd0, rp}, {24'd0, base});
      chk("R5 busy", {31'd0, busy}, 32'd1);
      chk("R5 write enable", {31'd0, ramWe}, 32'd1);
      chk("R5 write addr", {24'd0, ramAddr}, {24'd0, base + 8'(k)});
      chk("R5 write data", {28'd0, ramWdata}, {28'd0, val[k*4 +: 4]});
    end
    @(negedge clk);
    cmdValid = 1'b0; cmd = 3'd0;
    chk("R5 busy released", {31'd0, busy}, 32'd0);
  endtask

  task automatic retPop(input logic [11:0] expVal, input logic [7:0] base);
    @(negedge clk);
    cmdValid = 1'b1; cmd = 3'd4;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      cmdValid = 1'b0; cmd = 3'd0;
      chk("R7 busy", {31'd0, busy}, 32'd1);
      chk("R7 read addr", {24'd0, ramAddr}, {24'd0, base + 8'(k)});
      chk("R7 no write", {31'd0, ramWe}, 32'd0);
      chk("R7 no early valid", {31'd0, retValid}, 32'd0);
    end
    @(negedge clk);
    chk("R7 valid", {31'd0, retValid}, 32'd1);
    chk("R7 value", {20'd0, retOut}, {20'd0, expVal});
    chk("R7 rp after pop", {24'd0, rp}, {24'd0, base - 8'd4});
    chk("R7 busy low", {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk("R7 single pulse", {31'd0, retValid}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired (R1..) actual=hung expected=done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = 4'h0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", {31'd0, busy}, 32'd0);
    chk("R1 retValid in reset", {31'd0, retValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", {31'd0, busy}, 32'd0);
    chk("R1 no write after reset", {31'd0, ramWe}, 32'd0);
    chk("R1 retValid after reset", {31'd0, retValid}, 32'd0);

    // expression stack table
    for (int i = 0; i < 12; i++) begin
      issue(VEC[i][23:21], VEC[i][20:13], 12'h000);
      chk("R2/R3/R4 sp", {24'd0, sp}, {24'd0, VEC[i][7:0]});
      if (VEC[i][12]) chk("R2/R3 tos", {28'd0, tos}, {28'd0, VEC[i][11:8]});
    end

    // R2 accept-cycle write address and data
    @(negedge clk);
    cmdValid = 1'b1; cmd = 3'd1; pushNib = 4'h2;
    #1 chk("R2 write addr", {24'd0, ramAddr}, 32'h00);
    chk("R2 write data", {28'd0, ramWdata}, 32'h7);
    @(negedge clk);
    cmdValid = 1'b0;
    issue(3'd2, 8'h00, 12'h000);
    chk("R3 tos back", {28'd0, tos}, 32'h7);

    // R4 pointer load makes no write
    @(negedge clk);
    cmdValid = 1'b1; cmd = 3'd6; ldVal = 8'hFC;
    #1 chk("R4 no write on load", {31'd0, ramWe}, 32'd0);
    @(negedge clk);
    cmdValid = 1'b0;
    chk("R4 rp loaded", {24'd0, rp}, 32'hFC);

    // return stack, slot gap markers
    mem[8'h03] = 4'hE;
    mem[8'h07] = 4'h6;
    retPush(12'h9B3, 8'h00);  // R9 FC wraps to 00
    chk("R8 sp kept", {24'd0, sp}, 32'hFF);
    chk("R8 tos kept", {28'd0, tos}, 32'h7);
    retPush(12'h4D2, 8'h04);
    chk("R6 gap nibble slot 0", {28'd0, mem[8'h03]}, 32'hE);
    chk("R6 gap nibble slot 1", {28'd0, mem[8'h07]}, 32'h6);
    retPop(12'h4D2, 8'h04);
    retPop(12'h9B3, 8'h00);   // R9 00 wraps to FC
    chk("R9 rp wrapped", {24'd0, rp}, 32'hFC);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule